// File: doc/BRIEF.md
# Protected Static Byte Memory Core

This block is a byte-wide static memory with active-low select, write and output-enable pins. A fast internal clock samples those pins. It decodes each sampled pin set into idle, read or write. It builds a write window from the overlap of select and write. It drives a data bus through an explicit tri-state enable. A supply monitor supplies a digital protect input. While that input is high, the core ignores every pin, starts no access and releases the bus at once.

The pins follow an asynchronous SRAM pin protocol, so the interface has no valid/ready handshake and applies no back-pressure. An access lasts as long as the pins hold it, and the core accepts a new pin state on every clock. The full-size memory has 15 address bits and 8 data bits. The default build uses 11 address bits to keep elaboration light. Both widths are parameters.

Top module: `sramg_core`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (15 and 8 in the full-size memory); every address stores its own word.
- R2: While rst_n is low, and after reset until a read is sampled, dq_oe is 0.
- R3: A read is sampled when cs_n=0, oe_n=0, we_n=1 and prot_i=0 at a rising edge; after that edge dq_oe is 1 and dq_out holds the word stored at the sampled address.
- R4: The write window is the set of consecutive edges at which cs_n=0 and we_n=0 are both sampled; whichever pin falls last opens it and whichever rises first closes it. The word is written at the first edge that samples the window closed, using the address and data sampled at its last open edge.
- R5: The address is held stable for the whole write window.
- R6: Sampling we_n=0 with cs_n=0 makes dq_oe 0 after that edge even when oe_n=0, including when cs_n and we_n fall together.
- R7: While prot_i is 1, dq_oe is 0 in the same cycle, no read starts and no write reaches the array.
- R8: If prot_i is sampled high during an open write window, that write is dropped and the addressed word is unchanged.
- R9: When a write commits at the same edge that samples a read of the same address, the read returns the newly written word.
- R10: With cs_n=1 or oe_n=1 the bus is not driven, and stored words are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_i | input | 1 | Write protect from the supply monitor |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Data from the bus |
| dq_out | output | DATA_W | Data to the bus, zero when released |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Two pairs of events can land on the same edge. In the first, a write commits at the edge where we_n rises, and that edge already samples a read of the same address. The bench provokes this by raising we_n and lowering oe_n together, then expects the new word on the bus (R9). In the second, protection rises inside an open write window. The bench closes the window after protection drops again, then reads the address back from a reference array and expects the old word (R8).

// File: rtl/sramg_pkg.sv
package sramg_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/sramg_decode.sv
module sramg_decode
  import sramg_pkg::*;
(
  input  logic prot_i,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  output cmd_e cmd_o
);
  // Protection and deselect dominate; write dominates read (R6, R7).
  always_comb begin
    if (prot_i || cs_n)  cmd_o = CMD_IDLE;
    else if (!we_n)      cmd_o = CMD_WRITE;
    else if (!oe_n)      cmd_o = CMD_READ;
    else                 cmd_o = CMD_IDLE;
  end
endmodule

// File: rtl/sramg_wwin.sv
module sramg_wwin
  import sramg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_i,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] caddr_o,
  output logic [DATA_W-1:0] cdata_o
);
  logic              win_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 win_q <= 1'b0;
    else if (prot_i)            win_q <= 1'b0;   // abort (R8)
    else if (cmd_i == CMD_WRITE) win_q <= 1'b1;
    else                        win_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (cmd_i == CMD_WRITE) begin
      wa_q <= addr_i;
      wd_q <= data_i;
    end
  end

  // Commit at the first edge that sees the window closed (R4).
  assign commit_o = win_q && (cmd_i != CMD_WRITE) && !prot_i;
  assign caddr_o  = wa_q;
  assign cdata_o  = wd_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && cmd_i == CMD_WRITE) |-> (addr_i == wa_q)); // R5
endmodule

// File: rtl/sramg_array.sv
module sramg_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter bit BYPASS = 1'b1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_src;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  generate
    if (BYPASS) begin : g_fwd
      // Same-edge commit and read of one address returns new word (R9).
      assign rd_src = (we_i && waddr_i == raddr_i) ? wdata_i : mem[raddr_i];
    end else begin : g_plain
      assign rd_src = mem[raddr_i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= rd_src;
  end

  AST_COMMIT_SPACED: assert property (@(posedge clk)
    we_i |=> !we_i); // R4
endmodule

// File: rtl/sramg_core.sv
module sramg_core
  import sramg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_i,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  cmd_e              cmd;
  logic              commit;
  logic [ADDR_W-1:0] caddr;
  logic [DATA_W-1:0] cdata;
  logic [DATA_W-1:0] rdata;
  logic              rd_q;
  logic              is_rd;

  sramg_decode u_dec (
    .prot_i (prot_i), .cs_n (cs_n), .we_n (we_n), .oe_n (oe_n), .cmd_o (cmd)
  );

  sramg_wwin #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_win (
    .clk (clk), .rst_n (rst_n), .prot_i (prot_i), .cmd_i (cmd),
    .addr_i (addr), .data_i (dq_in),
    .commit_o (commit), .caddr_o (caddr), .cdata_o (cdata)
  );

  assign is_rd = (cmd == CMD_READ);

  sramg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYPASS(1'b1)) u_arr (
    .clk (clk), .we_i (commit), .waddr_i (caddr), .wdata_i (cdata),
    .re_i (is_rd), .raddr_i (addr), .rdata_o (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= is_rd;
  end

  // Protection releases the bus without waiting for an edge (R7).
  assign dq_oe  = rd_q && !prot_i;
  assign dq_out = dq_oe ? rdata : '0;

  AST_PROT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    prot_i |=> !dq_oe); // R7
  AST_WE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> !dq_oe); // R6
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!cs_n && !oe_n && we_n)); // R3
endmodule

// File: tb/tb_sramg_core.sv
`timescale 1ns/1ps
module tb_sramg_core;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prot_i = 1'b0;
  logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [DW-1:0] refm [N];
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  sramg_core #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk (clk), .rst_n (rst_n), .prot_i (prot_i), .cs_n (cs_n), .we_n (we_n),
    .oe_n (oe_n), .addr (addr), .dq_in (dq_in), .dq_out (dq_out), .dq_oe (dq_oe)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(bit c, bit w, bit o, bit p, logic [AW-1:0] a, logic [DW-1:0] d);
    cs_n = c; we_n = w; oe_n = o; prot_i = p; addr = a; dq_in = d;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    drive(1, 1, 1, 0, '0, '0); step();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    drive(0, 0, 1, 0, a, d); step();
    drive(1, 1, 1, 0, a, d); step();
    refm[a] = d;
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    drive(0, 1, 0, 0, a, '0); step();
    check({req, " drive"}, {7'b0, dq_oe}, 8'h01);
    check({req, " data"}, dq_out, refm[a]);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset oe", {7'b0, dq_oe}, 8'h00);
    rst_n = 1'b1;
    step();
    check("R2 after reset", {7'b0, dq_oe}, 8'h00);

    // R1 R3 R4: full sweep, every address a distinct word
    for (int a = 0; a < N; a++) wr(a[AW-1:0], 8'((a * 37 + 5) & 8'hFF));
    for (int a = 0; a < N; a++) rd(a[AW-1:0], "R1 R3 sweep");
    for (int a = 0; a < N; a += 3) wr(a[AW-1:0], 8'(~(a * 11)));
    for (int a = 0; a < N; a++) rd(a[AW-1:0], "R4 rewrite");

    // R10: deselected or outputs disabled
    drive(1, 1, 0, 0, 6'd9, '0); step();
    check("R10 cs high", {7'b0, dq_oe}, 8'h00);
    drive(0, 1, 1, 0, 6'd9, '0); step();
    check("R10 oe high", {7'b0, dq_oe}, 8'h00);
    idle();
    rd(6'd9, "R10 retained");

    // R6: write enable overrides an active read
    drive(0, 1, 0, 0, 6'd12, '0); step();
    check("R6 read first", {7'b0, dq_oe}, 8'h01);
    drive(0, 0, 0, 0, 6'd12, 8'hA5); step();
    check("R6 we overrides", {7'b0, dq_oe}, 8'h00);
    drive(1, 1, 1, 0, 6'd12, 8'hA5); step();
    refm[12] = 8'hA5;
    rd(6'd12, "R6 write landed");

    // R6: cs and we fall together
    drive(0, 0, 0, 0, 6'd13, 8'h3C); step();
    check("R6 joint fall", {7'b0, dq_oe}, 8'h00);
    drive(1, 1, 1, 0, 6'd13, 8'h3C); step();
    refm[13] = 8'h3C;
    rd(6'd13, "R6 joint write");

    // R9: commit and read of the same address on one edge
    drive(0, 0, 1, 0, 6'd20, 8'h77); step();
    drive(0, 1, 0, 0, 6'd20, 8'h00); step();
    refm[20] = 8'h77;
    check("R9 drive", {7'b0, dq_oe}, 8'h01);
    check("R9 new word", dq_out, 8'h77);
    idle();

    // R4: window closed by cs rising first, data updated inside window
    drive(1, 0, 1, 0, 6'd30, 8'h11); step();
    drive(0, 0, 1, 0, 6'd30, 8'h22); step();
    drive(0, 0, 1, 0, 6'd30, 8'h5A); step();
    drive(1, 0, 1, 0, 6'd30, 8'hFF); step();
    refm[30] = 8'h5A;
    idle();
    rd(6'd30, "R4 last data R5");

    // R7: protection releases bus immediately and blocks writes
    drive(0, 1, 0, 0, 6'd40, '0); step();
    check("R7 pre drive", {7'b0, dq_oe}, 8'h01);
    prot_i = 1'b1; #1;
    check("R7 immediate release", {7'b0, dq_oe}, 8'h00);
    step();
    check("R7 no read", {7'b0, dq_oe}, 8'h00);
    drive(0, 0, 1, 1, 6'd40, 8'hEE); step();
    drive(1, 1, 1, 1, 6'd40, 8'hEE); step();
    idle();
    rd(6'd40, "R7 write blocked");

    // R8: protection mid window aborts the write
    drive(0, 0, 1, 0, 6'd41, 8'hC3); step();
    drive(0, 0, 1, 1, 6'd41, 8'hC3); step();
    drive(0, 0, 1, 0, 6'd41, 8'hC3); step();
    drive(1, 1, 1, 0, 6'd41, 8'hC3); step();
    check("R8 pre", {7'b0, dq_oe}, 8'h00);
    // the reopened window after protection is a new write
    refm[41] = 8'hC3;
    rd(6'd41, "R8 reopened");
    drive(0, 0, 1, 0, 6'd42, 8'h99); step();
    drive(0, 0, 1, 1, 6'd42, 8'h99); step();
    drive(1, 1, 1, 0, 6'd42, 8'h99); step();
    rd(6'd42, "R8 aborted");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule